// File: doc/BRIEF.md
# GPIO Controller with Per-Line Interrupt Detection

This block is a sixteen-line general-purpose I/O controller that sits on a simple 32-bit register bus with a write strobe, a byte address and a combinational read port. Software sets the value each line drives, chooses per line whether the line is driven or sampled, and reads back the sampled pad levels through a read-only register. The pad inputs pass through a two-flop synchronizer before any register or detector sees them.

Every line also has a 3-bit detection mode. The modes for lines 0 to 7 sit in one style register and those for lines 8 to 15 in a second one. A detected condition sets a sticky status bit, and software clears it by writing ones. Level modes keep setting the status for as long as the condition holds. Edge modes set it once per qualifying edge. Lines 0 to 12 each drive one active-high request level toward a parent interrupt controller.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, the output data, status and both style registers read 0, the direction register reads 0xFFFF, `pad_oe` is 0 and `irq_req` is 0.
- R2: Word registers sit at these byte addresses: output data 0x00, direction 0x04, pad input 0x08 (read-only), status 0x0C, style for lines 0 to 7 at 0x10, style for lines 8 to 15 at 0x14. Bits above 15 (above 23 for the style registers) read 0. Any other address reads 0, and writes to it are ignored. Writes to 0x08 have no effect.
- R3: A direction bit of 1 makes the line an input (`pad_oe` bit 0). A direction bit of 0 sets `pad_oe` to 1, and `pad_out` carries the output data bit.
- R4: Register 0x08 returns all 16 synchronized pad values whatever the direction. A pad change is visible there after the second rising clock edge.
- R5: Line n (n below 8) takes its mode from bits [3n+2:3n] of 0x10, and line n+8 takes it from the same bits of 0x14. The codes are: 0 level high, 1 level low, 2 rising edge, 3 falling edge, 4 either edge. Codes 5, 6 and 7 detect nothing.
- R6: In an edge mode, one qualifying edge sets the status bit, and the bit stays set until software clears it.
- R7: In a level mode, the status bit is set again on every cycle while the condition holds, even directly after a clear.
- R8: Writing 1 to a bit of 0x0C clears that status bit, and writing 0 leaves it unchanged. If a detection and a clear hit the same bit in the same cycle, the bit ends up set.
- R9: `irq_req[n]` equals status bit n for n from 0 to 12, as an active-high level. Status bits 13 to 15 can be read but drive no request.
- R10: A status bit, and its request, rises on the third rising clock edge after the pad change that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe; the write takes effect at the rising edge |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 16 | Asynchronous pad levels |
| pad_out | output | 16 | Output data register value |
| pad_oe | output | 16 | Per-line output enable, 1 drives the pad |
| irq_req | output | 13 | Active-high request levels for lines 0 to 12 |

## Verification
Each result has its own latency. A register write appears on the combinational read port one edge after the strobe. A pad change reaches the input register after two edges, and the status bit and its request after three. Table rows therefore hold the pads steady for four edges before they write or read, and every value is sampled 1 ns after an edge. Two directed tests count single edges. One shows the input bit and the request rising on exactly the second and third edges. The other places a clear strobe on the same edge as a detection and checks that the bit stays set.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int unsigned GPIO_LINES = 16;
  localparam int unsigned GPIO_IRQS  = 13;
  localparam int unsigned MODE_W     = 3;
  localparam int unsigned BUS_DW     = 32;
  localparam int unsigned BUS_AW     = 5;

  // word indices (byte address / 4)
  localparam int unsigned REG_DOUT   = 0;
  localparam int unsigned REG_DIR    = 1;
  localparam int unsigned REG_PIN    = 2;
  localparam int unsigned REG_STAT   = 3;
  localparam int unsigned REG_STY_LO = 4;
  localparam int unsigned REG_STY_HI = 5;

  typedef enum logic [2:0] {
    MODE_LVL_HI = 3'd0,
    MODE_LVL_LO = 3'd1,
    MODE_RISE   = 3'd2,
    MODE_FALL   = 3'd3,
    MODE_ANY    = 3'd4
  } irq_mode_e;

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned LINES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] pad_in,
  output logic [LINES-1:0] cur,
  output logic [LINES-1:0] prev
);

  logic [LINES-1:0] meta_q, sync_q, prev_q;
  logic [LINES-1:0] meta_d, sync_d, prev_d;

  always_comb begin
    meta_d = pad_in;
    sync_d = meta_q;
    prev_d = sync_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign cur  = sync_q;
  assign prev = prev_q;

endmodule

// File: rtl/gpio_detect.sv
module gpio_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned LINES   = 16,
  parameter int unsigned MW      = 3,
  parameter int unsigned HALF    = LINES / 2,
  parameter int unsigned STYLE_W = HALF * MW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LINES-1:0]   cur,
  input  logic [LINES-1:0]   prev,
  input  logic [STYLE_W-1:0] style_lo,
  input  logic [STYLE_W-1:0] style_hi,
  output logic [LINES-1:0]   hit
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [MW-1:0] mode;

    if (g < HALF) begin : g_lo
      assign mode = style_lo[g*MW +: MW];
    end else begin : g_hi
      assign mode = style_hi[(g-HALF)*MW +: MW];
    end

    always_comb begin
      case (mode)
        MW'(MODE_LVL_HI): hit[g] = cur[g];
        MW'(MODE_LVL_LO): hit[g] = ~cur[g];
        MW'(MODE_RISE):   hit[g] = cur[g] & ~prev[g];
        MW'(MODE_FALL):   hit[g] = ~cur[g] & prev[g];
        MW'(MODE_ANY):    hit[g] = cur[g] ^ prev[g];
        default:          hit[g] = 1'b0;
      endcase
    end

    // R5
    undefined_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode > MW'(MODE_ANY)) |-> !hit[g]);
  end

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned LINES   = 16,
  parameter int unsigned AW      = 5,
  parameter int unsigned DW      = 32,
  parameter int unsigned STYLE_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [AW-1:0]      bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  input  logic [LINES-1:0]   pin_sync,
  input  logic [LINES-1:0]   set_vec,
  output logic [LINES-1:0]   dout,
  output logic [LINES-1:0]   dir,
  output logic [STYLE_W-1:0] style_lo,
  output logic [STYLE_W-1:0] style_hi,
  output logic [LINES-1:0]   status
);

  localparam int unsigned IW = AW - 2;

  logic [IW-1:0] idx;
  logic we_dout, we_dir, we_stat, we_lo, we_hi;

  logic [LINES-1:0]   dout_q, dir_q, stat_q;
  logic [LINES-1:0]   dout_d, dir_d, stat_d, clr_mask;
  logic [STYLE_W-1:0] lo_q, hi_q, lo_d, hi_d;

  logic unused_bits;
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[DW-1:STYLE_W]};

  assign idx = bus_addr[AW-1:2];

  // decode and next state
  always_comb begin
    we_dout  = bus_wr && (idx == IW'(REG_DOUT));
    we_dir   = bus_wr && (idx == IW'(REG_DIR));
    we_stat  = bus_wr && (idx == IW'(REG_STAT));
    we_lo    = bus_wr && (idx == IW'(REG_STY_LO));
    we_hi    = bus_wr && (idx == IW'(REG_STY_HI));
    dout_d   = bus_wdata[LINES-1:0];
    dir_d    = bus_wdata[LINES-1:0];
    lo_d     = bus_wdata[STYLE_W-1:0];
    hi_d     = bus_wdata[STYLE_W-1:0];
    clr_mask = we_stat ? bus_wdata[LINES-1:0] : '0;
    stat_d   = (stat_q & ~clr_mask) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      dir_q  <= '1;
      stat_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else begin
      if (we_dout) dout_q <= dout_d;
      if (we_dir)  dir_q  <= dir_d;
      if (we_lo)   lo_q   <= lo_d;
      if (we_hi)   hi_q   <= hi_d;
      stat_q <= stat_d;
    end
  end

  // read mux, upper bits zero
  always_comb begin
    bus_rdata = '0;
    case (idx)
      IW'(REG_DOUT):   bus_rdata[LINES-1:0]   = dout_q;
      IW'(REG_DIR):    bus_rdata[LINES-1:0]   = dir_q;
      IW'(REG_PIN):    bus_rdata[LINES-1:0]   = pin_sync;
      IW'(REG_STAT):   bus_rdata[LINES-1:0]   = stat_q;
      IW'(REG_STY_LO): bus_rdata[STYLE_W-1:0] = lo_q;
      IW'(REG_STY_HI): bus_rdata[STYLE_W-1:0] = hi_q;
      default:         bus_rdata = '0;
    endcase
  end

  assign dout     = dout_q;
  assign dir      = dir_q;
  assign style_lo = lo_q;
  assign style_hi = hi_q;
  assign status   = stat_q;

  // R8
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_mask & ~set_vec)) |=> ((stat_q & $past(clr_mask & ~set_vec)) == '0));

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((stat_q & $past(set_vec)) == $past(set_vec)));

  // R6
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_stat && (set_vec == '0)) |=> $stable(stat_q));

  // R2
  dir_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_dir |=> $stable(dir_q));

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned LINES = GPIO_LINES,
  parameter int unsigned IRQS  = GPIO_IRQS,
  parameter int unsigned AW    = BUS_AW,
  parameter int unsigned DW    = BUS_DW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [LINES-1:0] pad_in,
  output logic [LINES-1:0] pad_out,
  output logic [LINES-1:0] pad_oe,
  output logic [IRQS-1:0]  irq_req
);

  localparam int unsigned HALF    = LINES / 2;
  localparam int unsigned STYLE_W = HALF * MODE_W;

  logic               rst_i_n;
  logic [LINES-1:0]   cur, prev, hit, dout, dir, status;
  logic [STYLE_W-1:0] style_lo, style_hi;

  gpio_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  gpio_in_sync #(.LINES(LINES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .pad_in (pad_in),
    .cur    (cur),
    .prev   (prev)
  );

  gpio_detect #(.LINES(LINES), .MW(MODE_W), .HALF(HALF), .STYLE_W(STYLE_W)) u_det (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .cur      (cur),
    .prev     (prev),
    .style_lo (style_lo),
    .style_hi (style_hi),
    .hit      (hit)
  );

  gpio_irq_regs #(.LINES(LINES), .AW(AW), .DW(DW), .STYLE_W(STYLE_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_sync  (cur),
    .set_vec   (hit),
    .dout      (dout),
    .dir       (dir),
    .style_lo  (style_lo),
    .style_hi  (style_hi),
    .status    (status)
  );

  logic unused_status;
  assign unused_status = ^status[LINES-1:IRQS];

  assign pad_out = dout;
  assign pad_oe  = ~dir;
  assign irq_req = status[IRQS-1:0];

  // R9
  irq_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(irq_req[0]) |-> $past(hit[0]));

endmodule

// File: tb/gpio_irq_ctrl_tb.sv
`timescale 1ns/100ps
module gpio_irq_ctrl_tb;

  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [15:0] pad_in;
  logic [15:0] pad_out;
  logic [15:0] pad_oe;
  logic [12:0] irq_req;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  gpio_irq_ctrl u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .irq_req   (irq_req)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [15:0] pad;
    logic        wr;
    logic [4:0]  waddr;
    logic [31:0] wdata;
    logic [4:0]  raddr;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{16'h0000, 1'b1, 5'h00, 32'h1234ABCD, 5'h00, 32'h0000ABCD, 4'd2}, // R2 upper bits zero
    '{16'h0000, 1'b1, 5'h04, 32'h0000FF00, 5'h04, 32'h0000FF00, 4'd2}, // R2
    '{16'h5A5A, 1'b0, 5'h00, 32'h0,        5'h08, 32'h00005A5A, 4'd4}, // R4
    '{16'h5A5A, 1'b0, 5'h00, 32'h0,        5'h0C, 32'h00005A5A, 4'd7}, // R7 level high default
    '{16'h0000, 1'b1, 5'h0C, 32'h0000FFFF, 5'h0C, 32'h00000000, 4'd8}, // R8
    '{16'h0000, 1'b1, 5'h10, 32'h00492492, 5'h10, 32'h00492492, 4'd5}, // R5 lines 0-7 rising
    '{16'h0000, 1'b1, 5'h14, 32'h006DB6DB, 5'h14, 32'h006DB6DB, 4'd5}, // R5 lines 8-15 falling
    '{16'hFFFF, 1'b0, 5'h00, 32'h0,        5'h0C, 32'h000000FF, 4'd6}, // R6 rise
    '{16'h0000, 1'b0, 5'h00, 32'h0,        5'h0C, 32'h0000FFFF, 4'd6}, // R6 fall + sticky
    '{16'h0000, 1'b1, 5'h0C, 32'h00000F0F, 5'h0C, 32'h0000F0F0, 4'd8}, // R8 zeros keep
    '{16'h0000, 1'b1, 5'h08, 32'h0000FFFF, 5'h08, 32'h00000000, 4'd2}, // R2 read-only
    '{16'h0000, 1'b1, 5'h18, 32'h0000FFFF, 5'h18, 32'h00000000, 4'd2}  // R2 unmapped
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    bus_wr    = 1'b1;
    bus_addr  = a;
    bus_wdata = d;
    step();
    bus_wr    = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  logic [31:0] rd;

  initial begin
    bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; pad_in = '0;
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) step();

    // R1 reset state
    check("R1 pad_oe", {16'h0, pad_oe}, 32'h0);
    check("R1 pad_out", {16'h0, pad_out}, 32'h0);
    check("R1 irq_req", {19'h0, irq_req}, 32'h0);
    bus_read(5'h04, rd); check("R1 dir", rd, 32'h0000FFFF);
    bus_read(5'h0C, rd); check("R1 status", rd, 32'h0);
    bus_read(5'h10, rd); check("R1 style lo", rd, 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      pad_in = TBL[i].pad;
      repeat (4) step();
      if (TBL[i].wr) begin
        bus_write(TBL[i].waddr, TBL[i].wdata);
      end
      bus_read(TBL[i].raddr, rd);
      check($sformatf("R%0d row %0d", TBL[i].req, i), rd, TBL[i].exp);
    end

    // R3 direction and output data (dir=FF00, data=ABCD)
    check("R3 pad_oe", {16'h0, pad_oe}, 32'h000000FF);
    check("R3 pad_out", {16'h0, pad_out}, 32'h0000ABCD);

    // R9 status F0F0 -> requests for lines 0..12
    check("R9 irq_req", {19'h0, irq_req}, 32'h000010F0);

    // R5 modes: line0 any, line1 code 5, line2 level low, others code 7
    pad_in = 16'h0004;
    repeat (4) step();
    bus_write(5'h10, 32'h00FFFE6C);
    bus_write(5'h0C, 32'h0000FFFF);
    repeat (4) step();
    bus_read(5'h0C, rd); check("R5 quiet", rd, 32'h0);
    pad_in = 16'h0003;
    repeat (4) step();
    bus_read(5'h0C, rd); check("R5 any/none/low", rd, 32'h00000005);

    // R7 level low re-sets right after clear; line0 falling in any mode
    bus_write(5'h0C, 32'h0000FFFF);
    pad_in = 16'h0002;
    repeat (4) step();
    bus_read(5'h0C, rd); check("R7 level after clear", rd, 32'h00000005);

    // R10 latency, R4 input latency
    bus_write(5'h0C, 32'h0000FFFF);
    step();
    bus_addr = 5'h08;
    pad_in = 16'h0003;
    step();
    check("R4 edge1 input", {31'h0, bus_rdata[0]}, 32'h0);
    step();
    check("R4 edge2 input", {31'h0, bus_rdata[0]}, 32'h1);
    check("R10 edge2 irq", {31'h0, irq_req[0]}, 32'h0);
    step();
    check("R10 edge3 irq", {31'h0, irq_req[0]}, 32'h1);

    // R8 set wins over same-cycle clear
    repeat (2) step();
    bus_write(5'h0C, 32'h0000FFFF);
    step();
    pad_in = 16'h0002;
    repeat (2) step();
    bus_write(5'h0C, 32'h00000001);
    bus_read(5'h0C, rd); check("R8 set wins", {31'h0, rd[0]}, 32'h1);
    bus_write(5'h0C, 32'h00000001);
    bus_read(5'h0C, rd); check("R8 later clear", {31'h0, rd[0]}, 32'h0);

    done = 1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule